// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer on APB

This block is a watchdog timer that sits on an APB slave port and exposes 32-bit registers. A down-counter decrements by one on every clock cycle in which the `tick_en` input is high. When the counter runs out the first time, the block raises its raw interrupt flag and reloads the counter from the programmed reload value. If software has not cleared the interrupt by the time the counter runs out again, the block sets a sticky reset-request flag and stops counting. The interrupt and reset outputs are each gated by their own enable bit in the control register.

Configuration writes are blocked while the block is locked. A write to the lock register with the unlock key reopens the block, and a write of any other value closes it again. An integration-test mode lets software drive the two outputs directly. The parameter `FREEZE` selects a variant with two differences: its control register can no longer be written once the interrupt enable is set, and it has no test registers. Identification words near the top of the 4 KiB window give the part number and revision.

Top module: `wdt_apb`

## Requirements
- R1: After reset, the reload value and the counter are both 0xFFFFFFFF and the counter is running. The control bits are 0, both flags are clear, the block is unlocked, and `irq_o` and `rst_req_o` are low.
- R2: The control register at 0x008 holds the interrupt enable in bit 0 and the reset enable in bit 1. All other bits are discarded when written and read back as 0.
- R3: A write to 0x000 sets the reload value and loads the counter with it, restarting the counter even if it had stopped. 0x000 reads the reload value and 0x004 reads the counter.
- R4: A tick at a count of 2 or more decrements the counter. A tick at a count of 1 or 0 is an expiry. If the raw flag is clear, an expiry sets the raw flag and reloads the counter. If the raw flag is already set, an expiry sets the reset-request flag, clears the counter and stops it. The reset-request flag then stays set until reset, and the counter stays stopped until the next write to 0x000.
- R5: A write of any value to 0x00C clears the raw flag and loads the counter from the reload value. It does not restart a stopped counter.
- R6: `irq_o` equals the raw flag AND the interrupt enable, and `rst_req_o` equals the reset-request flag AND the reset enable. Bit 0 of 0x010 reads the raw flag and bit 0 of 0x014 reads the masked interrupt.
- R7: Writing 0x1ACCE551 to 0xC00 unlocks the block, and writing any other value there locks it. 0xC00 reads 1 when the block is locked and 0 when it is unlocked.
- R8: While the block is locked, every write except a write to 0xC00 is ignored.
- R9: When bit 0 of 0xF00 is set, `irq_o` follows bit 1 of 0xF04 and `rst_req_o` follows bit 0 of 0xF04, and the normal status is bypassed. 0xF00 reads back its bit 0.
- R10: With `FREEZE` set, writes to 0x008 are ignored once the interrupt enable is 1. In this variant, 0xF00 and 0xF04 are invalid offsets: they read 0 and ignore writes.
- R11: Reads of 0x00C, 0xF04, unmapped offsets and offsets that are not word aligned return 0. Writes to 0x004, 0x010, 0x014, the identification words and unmapped offsets have no effect. The identification words at 0xFD0 to 0xFFC read 0x04 at 0xFD0 and 0 at 0xFD4 to 0xFDC. At 0xFE0 to 0xFEC they read `PART_NO[7:0]`, {0xA, `PART_NO[11:8]`}, {`REV`, 0xB} and 0. At 0xFF0 to 0xFFC they read 0x0D, 0xF0, 0x05 and 0xB1.
- R12: `pready` is always 1 and `pslverr` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counter clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | Byte address within the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| tick_en | input | 1 | Counter decrement enable, one decrement per high cycle |
| irq_o | output | 1 | Watchdog interrupt |
| rst_req_o | output | 1 | Watchdog reset request |

## Verification
The assertions take for granted that a register write lasts exactly one cycle, with `psel`, `penable` and `pwrite` all high in that cycle. They also assume that `tick_en` is a clean synchronous level that is never X after reset. The stimulus meets both assumptions: every transfer is a two-cycle setup/access pair driven on falling edges, and `tick_en` is held low during bus transfers and pulsed only in counted bursts between them. Because of this, the exact count and flag values after each burst can be predicted.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned IDX_W  = ADDR_W - 2;
    localparam int unsigned DATA_W = 32;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    // word indices (byte offset / 4)
    localparam logic [IDX_W-1:0] IDX_RELOAD = 10'h000;
    localparam logic [IDX_W-1:0] IDX_COUNT  = 10'h001;
    localparam logic [IDX_W-1:0] IDX_CTRL   = 10'h002;
    localparam logic [IDX_W-1:0] IDX_ACK    = 10'h003;
    localparam logic [IDX_W-1:0] IDX_RAW    = 10'h004;
    localparam logic [IDX_W-1:0] IDX_MSK    = 10'h005;
    localparam logic [IDX_W-1:0] IDX_GATE   = 10'h300;
    localparam logic [IDX_W-1:0] IDX_TMODE  = 10'h3C0;
    localparam logic [IDX_W-1:0] IDX_TDRIVE = 10'h3C1;
    localparam logic [IDX_W-1:0] IDX_ID_LO  = 10'h3F4;
    localparam logic [IDX_W-1:0] IDX_ID_HI  = 10'h3FF;

    typedef struct packed {
        logic rst_en;   // bit 1
        logic irq_en;   // bit 0
    } wdt_ctrl_t;

    function automatic logic [7:0] id_byte(input logic [3:0] slot,
                                           input logic [11:0] part,
                                           input logic [3:0] rev);
        logic [7:0] b;
        case (slot)
            4'd0:    b = 8'h04;
            4'd4:    b = part[7:0];
            4'd5:    b = {4'hA, part[11:8]};
            4'd6:    b = {rev, 4'hB};
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             ld_we_i,
    input  logic [CNT_W-1:0] ld_val_i,
    input  logic             ack_we_i,
    output logic [CNT_W-1:0] reload_o,
    output logic [CNT_W-1:0] count_o,
    output logic             raw_o,
    output logic             rflag_o
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             raw;
        logic             rflag;
    } cnt_state_t;

    localparam cnt_state_t RST_STATE = '{
        reload: '1, cnt: '1, run: 1'b1, raw: 1'b0, rflag: 1'b0};

    cnt_state_t st_d, st_q;
    logic       expire;

    assign expire = st_q.run && tick_i && (st_q.cnt <= CNT_W'(1));

    always_comb begin
        st_d = st_q;
        if (st_q.run && tick_i) begin
            if (expire) begin
                if (!st_q.raw) begin
                    st_d.raw = 1'b1;
                    st_d.cnt = st_q.reload;
                end else begin
                    st_d.rflag = 1'b1;
                    st_d.run   = 1'b0;
                    st_d.cnt   = '0;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
        if (ack_we_i) begin
            st_d.raw = 1'b0;
            st_d.cnt = st_q.reload;
        end
        if (ld_we_i) begin
            st_d.reload = ld_val_i;
            st_d.cnt    = ld_val_i;
            st_d.run    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_STATE;
        else        st_q <= st_d;
    end

    assign reload_o = st_q.reload;
    assign count_o  = st_q.cnt;
    assign raw_o    = st_q.raw;
    assign rflag_o  = st_q.rflag;

    assert_second_stage_needs_raw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rflag) |-> $past(st_q.raw));

    assert_reset_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rflag |=> st_q.rflag);

    assert_ack_clears_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we_i |=> !st_q.raw);

    assert_load_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we_i |=> (st_q.cnt == $past(ld_val_i)) && st_q.run);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter bit FREEZE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              idx_ok_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              raw_i,
    input  logic              rflag_i,
    output logic              ld_we_o,
    output logic              ack_we_o,
    output wdt_ctrl_t         ctrl_o,
    output logic              locked_o,
    output logic              tmode_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    typedef struct packed {
        wdt_ctrl_t  ctrl;
        logic       locked;
        logic       tmode;
        logic [1:0] tdrive;   // [1] interrupt, [0] reset
    } reg_state_t;

    localparam reg_state_t RST_STATE = '{
        ctrl: '0, locked: 1'b0, tmode: 1'b0, tdrive: 2'b00};

    reg_state_t rg_d, rg_q;
    logic       wr_hit;

    assign wr_hit = wr_en_i && idx_ok_i;

    always_comb begin
        rg_d     = rg_q;
        ld_we_o  = 1'b0;
        ack_we_o = 1'b0;
        if (wr_hit) begin
            if (idx_i == IDX_GATE) begin
                rg_d.locked = (wdata_i != UNLOCK_KEY);
            end else if (!rg_q.locked) begin
                case (idx_i)
                    IDX_RELOAD: ld_we_o  = 1'b1;
                    IDX_ACK:    ack_we_o = 1'b1;
                    IDX_CTRL: begin
                        if (!(FREEZE && rg_q.ctrl.irq_en))
                            rg_d.ctrl = wdt_ctrl_t'(wdata_i[1:0]);
                    end
                    IDX_TMODE: begin
                        if (!FREEZE) rg_d.tmode = wdata_i[0];
                    end
                    IDX_TDRIVE: begin
                        if (!FREEZE) rg_d.tdrive = wdata_i[1:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= RST_STATE;
        else        rg_q <= rg_d;
    end

    assign ctrl_o    = rg_q.ctrl;
    assign locked_o  = rg_q.locked;
    assign tmode_o   = rg_q.tmode;
    assign irq_o     = rg_q.tmode ? rg_q.tdrive[1] : (raw_i   && rg_q.ctrl.irq_en);
    assign rst_req_o = rg_q.tmode ? rg_q.tdrive[0] : (rflag_i && rg_q.ctrl.rst_en);

    assert_locked_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.locked && wr_en_i && idx_i != IDX_GATE)
        |=> $stable(rg_q.ctrl) && $stable(rg_q.tmode) && $stable(rg_q.tdrive));

    assert_key_sets_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && idx_i == IDX_GATE) |=> (rg_q.locked == ($past(wdata_i) != UNLOCK_KEY)));

    assert_frozen_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (FREEZE && rg_q.ctrl.irq_en) |=> $stable(rg_q.ctrl));

    assert_no_test_regs_R10: assert property (@(posedge clk) disable iff (!rst_n)
        FREEZE |-> !rg_q.tmode);

endmodule

// File: rtl/wdt_rdmux.sv
module wdt_rdmux
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter bit          FREEZE  = 1'b0,
    parameter logic [11:0] PART_NO = 12'h5A3,
    parameter logic [3:0]  REV     = 4'h1
) (
    input  logic              idx_ok_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [CNT_W-1:0]  count_i,
    input  wdt_ctrl_t         ctrl_i,
    input  logic              raw_i,
    input  logic              locked_i,
    input  logic              tmode_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic       tmode_vis;
    logic [3:0] id_slot;

    generate
        if (FREEZE) begin : g_no_test
            assign tmode_vis = 1'b0;
        end else begin : g_test
            assign tmode_vis = tmode_i;
        end
    endgenerate

    assign id_slot = 4'(idx_i - IDX_ID_LO);

    always_comb begin
        rdata_o = '0;
        if (idx_ok_i) begin
            case (idx_i)
                IDX_RELOAD: rdata_o = DATA_W'(reload_i);
                IDX_COUNT:  rdata_o = DATA_W'(count_i);
                IDX_CTRL:   rdata_o = DATA_W'(ctrl_i);
                IDX_RAW:    rdata_o = DATA_W'(raw_i);
                IDX_MSK:    rdata_o = DATA_W'(raw_i && ctrl_i.irq_en);
                IDX_GATE:   rdata_o = DATA_W'(locked_i);
                IDX_TMODE:  rdata_o = DATA_W'(tmode_vis);
                default: begin
                    if (idx_i >= IDX_ID_LO && idx_i <= IDX_ID_HI)
                        rdata_o = DATA_W'(id_byte(id_slot, PART_NO, REV));
                end
            endcase
        end
    end

endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W   = 32,
    parameter bit          FREEZE  = 1'b0,
    parameter logic [11:0] PART_NO = 12'h5A3,
    parameter logic [3:0]  REV     = 4'h1
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              tick_en,
    output logic              irq_o,
    output logic              rst_req_o
);

    logic              wr_en;
    logic              idx_ok;
    logic [IDX_W-1:0]  idx;
    logic              ld_we, ack_we;
    logic [CNT_W-1:0]  reload_v, count_v;
    logic              raw, rflag, locked, tmode;
    wdt_ctrl_t         ctrl;

    assign wr_en   = psel && penable && pwrite;
    assign idx     = paddr[ADDR_W-1:2];
    assign idx_ok  = (paddr[1:0] == 2'b00);
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (pclk),
        .rst_n    (presetn),
        .tick_i   (tick_en),
        .ld_we_i  (ld_we),
        .ld_val_i (pwdata[CNT_W-1:0]),
        .ack_we_i (ack_we),
        .reload_o (reload_v),
        .count_o  (count_v),
        .raw_o    (raw),
        .rflag_o  (rflag)
    );

    wdt_regs #(.FREEZE(FREEZE)) u_regs (
        .clk       (pclk),
        .rst_n     (presetn),
        .wr_en_i   (wr_en),
        .idx_ok_i  (idx_ok),
        .idx_i     (idx),
        .wdata_i   (pwdata),
        .raw_i     (raw),
        .rflag_i   (rflag),
        .ld_we_o   (ld_we),
        .ack_we_o  (ack_we),
        .ctrl_o    (ctrl),
        .locked_o  (locked),
        .tmode_o   (tmode),
        .irq_o     (irq_o),
        .rst_req_o (rst_req_o)
    );

    wdt_rdmux #(.CNT_W(CNT_W), .FREEZE(FREEZE), .PART_NO(PART_NO), .REV(REV)) u_rd (
        .idx_ok_i (idx_ok),
        .idx_i    (idx),
        .reload_i (reload_v),
        .count_i  (count_v),
        .ctrl_i   (ctrl),
        .raw_i    (raw),
        .locked_i (locked),
        .tmode_i  (tmode),
        .rdata_o  (prdata)
    );

    assert_irq_follows_raw_R6: assert property (@(posedge pclk) disable iff (!presetn)
        (!tmode && ctrl.irq_en) |-> (irq_o == raw));

endmodule

// File: tb/sim_wdt_apb.sv
module sim_wdt_apb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 30;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel0 = 1'b0, psel1 = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic        tick = 1'b0;
    logic [31:0] prdata0, prdata1;
    logic        pready0, pready1, pslverr0, pslverr1;
    logic        irq0, irq1, rst0, rst1;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) pclk = ~pclk;

    wdt_apb #(.FREEZE(1'b0)) u0 (
        .pclk(pclk), .presetn(presetn), .psel(psel0), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata0),
        .pready(pready0), .pslverr(pslverr0), .tick_en(tick),
        .irq_o(irq0), .rst_req_o(rst0));

    wdt_apb #(.FREEZE(1'b1)) u1 (
        .pclk(pclk), .presetn(presetn), .psel(psel1), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata1),
        .pready(pready1), .pslverr(pslverr1), .tick_en(tick),
        .irq_o(irq1), .rst_req_o(rst1));

    // {write, addr, data-or-expected, requirement}
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 12'h008, 32'hFFFF_FFFF, 4'd2},
        {1'b0, 12'h008, 32'h0000_0003, 4'd2},   // R2 upper bits dropped
        {1'b1, 12'h008, 32'h0000_0001, 4'd2},
        {1'b0, 12'h008, 32'h0000_0001, 4'd2},
        {1'b1, 12'h000, 32'h0000_0010, 4'd3},
        {1'b0, 12'h004, 32'h0000_0010, 4'd3},   // R3 count loaded
        {1'b0, 12'h000, 32'h0000_0010, 4'd3},
        {1'b1, 12'h004, 32'h0000_0005, 4'd11},
        {1'b0, 12'h004, 32'h0000_0010, 4'd11},  // R11 RO write ignored
        {1'b0, 12'h00C, 32'h0000_0000, 4'd11},
        {1'b0, 12'h100, 32'h0000_0000, 4'd11},
        {1'b1, 12'h010, 32'h0000_0001, 4'd11},
        {1'b0, 12'h010, 32'h0000_0000, 4'd11},
        {1'b0, 12'hFD0, 32'h0000_0004, 4'd11},
        {1'b0, 12'hFE0, 32'h0000_00A3, 4'd11},
        {1'b0, 12'hFF0, 32'h0000_000D, 4'd11},
        {1'b0, 12'hFFC, 32'h0000_00B1, 4'd11},
        {1'b1, 12'hC00, 32'h0000_0000, 4'd7},
        {1'b0, 12'hC00, 32'h0000_0001, 4'd7},   // R7 locked reads 1
        {1'b1, 12'h008, 32'h0000_0000, 4'd8},
        {1'b0, 12'h008, 32'h0000_0001, 4'd8},   // R8 write blocked
        {1'b1, 12'h000, 32'h0000_0007, 4'd8},
        {1'b0, 12'h000, 32'h0000_0010, 4'd8},
        {1'b1, 12'hC00, 32'h1ACC_E551, 4'd7},
        {1'b0, 12'hC00, 32'h0000_0000, 4'd7},
        {1'b1, 12'h008, 32'h0000_0002, 4'd2},
        {1'b0, 12'h008, 32'h0000_0002, 4'd2},
        {1'b1, 12'h008, 32'h0000_0001, 4'd2},
        {1'b0, 12'h008, 32'h0000_0001, 4'd2},
        {1'b0, 12'h014, 32'h0000_0000, 4'd6}    // R6 masked status low
    };

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apb(input bit sel1, input bit wr, input logic [11:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
        @(negedge pclk);
        psel0 = !sel1; psel1 = sel1; pwrite = wr; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge pclk);
        penable = 1'b1;
        #1 rd = sel1 ? prdata1 : prdata0;
        @(negedge pclk);
        psel0 = 1'b0; psel1 = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge pclk);
        tick = 1'b1;
        repeat (n) @(negedge pclk);
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [48:0] v;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);

        // R1 reset state
        check(1, {31'd0, irq0}, 32'd0);
        check(1, {31'd0, rst0}, 32'd0);
        apb(0, 0, 12'h004, 0, rd); check(1, rd, 32'hFFFF_FFFF);
        ticks(3);
        apb(0, 0, 12'h004, 0, rd); check(1, rd, 32'hFFFF_FFFC);   // R4 decrement
        apb(0, 0, 12'h000, 0, rd); check(1, rd, 32'hFFFF_FFFF);
        apb(0, 0, 12'h008, 0, rd); check(1, rd, 32'h0);
        apb(0, 0, 12'h010, 0, rd); check(1, rd, 32'h0);
        apb(0, 0, 12'hC00, 0, rd); check(1, rd, 32'h0);
        check(12, {31'd0, pready0}, 32'd1);   // R12
        check(12, {31'd0, pslverr0}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            apb(0, v[48], v[47:36], v[35:4], rd);
            if (!v[48]) check(int'(v[3:0]), rd, v[35:4]);
        end

        // R4 two-stage expiry, interrupt enabled, reset disabled
        apb(0, 1, 12'h000, 32'd3, rd);
        ticks(2);
        apb(0, 0, 12'h004, 0, rd); check(4, rd, 32'd1);
        check(6, {31'd0, irq0}, 32'd0);
        ticks(1);
        apb(0, 0, 12'h010, 0, rd); check(4, rd, 32'd1);
        apb(0, 0, 12'h004, 0, rd); check(4, rd, 32'd3);
        apb(0, 0, 12'h014, 0, rd); check(6, rd, 32'd1);
        check(6, {31'd0, irq0}, 32'd1);
        ticks(3);
        apb(0, 0, 12'h004, 0, rd); check(4, rd, 32'd0);
        check(6, {31'd0, rst0}, 32'd0);
        apb(0, 1, 12'h008, 32'd3, rd);
        check(6, {31'd0, rst0}, 32'd1);
        ticks(4);
        apb(0, 0, 12'h004, 0, rd); check(4, rd, 32'd0);   // stopped

        // R5 clear
        apb(0, 1, 12'h00C, 32'h1234, rd);
        apb(0, 0, 12'h010, 0, rd); check(5, rd, 32'd0);
        check(5, {31'd0, irq0}, 32'd0);
        ticks(2);
        apb(0, 0, 12'h004, 0, rd); check(5, rd, 32'd3);
        check(4, {31'd0, rst0}, 32'd1);   // sticky
        apb(0, 1, 12'h000, 32'd8, rd);
        ticks(2);
        apb(0, 0, 12'h004, 0, rd); check(3, rd, 32'd6);

        // R9 test override
        apb(0, 1, 12'hF00, 32'd1, rd);
        apb(0, 1, 12'hF04, 32'd2, rd);
        check(9, {31'd0, irq0}, 32'd1);
        check(9, {31'd0, rst0}, 32'd0);
        apb(0, 1, 12'hF04, 32'd1, rd);
        check(9, {31'd0, irq0}, 32'd0);
        check(9, {31'd0, rst0}, 32'd1);
        apb(0, 0, 12'hF04, 0, rd); check(11, rd, 32'd0);
        apb(0, 0, 12'hF00, 0, rd); check(9, rd, 32'd1);
        apb(0, 0, 12'h001, 0, rd); check(11, rd, 32'd0);   // misaligned
        apb(0, 1, 12'hF00, 32'd0, rd);
        check(9, {31'd0, rst0}, 32'd1);

        // R10 frozen variant
        apb(1, 0, 12'h008, 0, rd); check(10, rd, 32'd0);
        apb(1, 1, 12'h008, 32'd2, rd);
        apb(1, 0, 12'h008, 0, rd); check(10, rd, 32'd2);
        apb(1, 1, 12'h008, 32'd1, rd);
        apb(1, 1, 12'h008, 32'd0, rd);
        apb(1, 0, 12'h008, 0, rd); check(10, rd, 32'd1);
        apb(1, 1, 12'hF00, 32'd1, rd);
        apb(1, 1, 12'hF04, 32'd2, rd);
        apb(1, 0, 12'hF00, 0, rd); check(10, rd, 32'd0);
        check(10, {31'd0, irq1}, 32'd0);
        check(12, {31'd0, pready1 & ~pslverr1}, 32'd1);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule